// File: doc/BRIEF.md
# Condition Compare and True-Bit Unit

This block decides the next value of a single true bit (T) for a processor that records comparison outcomes in one status bit rather than a set of arithmetic flags. Each operation is evaluated in one combinational pass. The inputs are an operation code, three 32-bit register operands (`rm`, `rn` and the index register `r0`), an 8-bit immediate and the present T bit. The outputs are the next T value and a 32-bit word that holds T for the move-T operation.

The block covers signed and unsigned ordering compares, two compares of `rn` against zero, an equality compare of `r0` against a sign-extended immediate, and a byte-lane string compare. It also provides a bitwise test in register and immediate forms, direct set and clear of T, and the move-T operation. Operations that do not touch T pass the present T through unchanged. The status register that holds T, the branch logic that consumes it and the register file all sit outside the block.

Top module: `tflag_unit`

## Requirements
- R1: Op code 1 (equal) gives T = 1 when `rn` equals `rm` and T = 0 otherwise.
- R2: Op codes 2 (signed greater-or-equal) and 3 (signed greater-than) compare `rn` against `rm` as two's-complement numbers. The result is correct across signed overflow, for example 0x7FFFFFFF > 0x80000000.
- R3: Op codes 4 (unsigned higher) and 5 (unsigned higher-or-same) compare `rn` against `rm` as unsigned numbers.
- R4: Op code 6 (positive) gives T = 1 when `rn` is strictly greater than zero as a signed number. Op code 7 (non-negative) gives T = 1 when `rn` is zero or more.
- R5: Op code 8 (string) gives T = 1 when at least one of the four byte lanes (bits 7:0, 15:8, 23:16, 31:24) of `rn` equals the same lane of `rm`. Equal bytes that sit in different lanes do not set T.
- R6: Op code 9 (immediate equal) gives T = 1 when `r0` equals `imm` sign-extended from bit 7 to 32 bits.
- R7: Op code 10 (register test) gives T = 1 when `rn & rm` is zero. Op code 11 (immediate test) gives T = 1 when `r0 & zero-extended imm` is zero. Neither form has any data output.
- R8: Op code 12 forces T to 1 and op code 13 forces T to 0, whatever the operands are.
- R9: Op code 14 (move T) drives `movt_val` = {31'b0, `t_in`} and leaves T unchanged. For every other op code, `movt_val` is zero.
- R10: Op code 0 (none) and the unused op code 15 give `t_next` = `t_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code (see requirements) |
| rm | input | 32 | Source register operand |
| rn | input | 32 | Destination-side register operand |
| r0 | input | 32 | Index register operand, used by the immediate forms |
| imm | input | 8 | Immediate field |
| t_in | input | 1 | Present T bit |
| t_next | output | 1 | Next T bit |
| movt_val | output | 32 | T zero-extended for move-T; zero otherwise |

## Verification
The checker assumes that all inputs are stable, two-state values when its combinational assertions evaluate. It also assumes that `op` is any 4-bit value, including the unused code. The bench changes inputs only just after a rising clock edge and reads the outputs at the falling edge. All 16 op codes are driven, and operands are chosen to sit on the signed and unsigned wrap points, the byte-lane boundaries and the sign bit of the immediate.

// File: rtl/tflag_pkg.sv
package tflag_pkg;

  localparam int DATA_W = 32;
  localparam int IMM_W  = 8;
  localparam int LANE_W = 8;

  typedef enum logic [3:0] {
    OP_NONE  = 4'd0,
    OP_EQ    = 4'd1,
    OP_SGE   = 4'd2,
    OP_SGT   = 4'd3,
    OP_UGT   = 4'd4,
    OP_UGE   = 4'd5,
    OP_POS   = 4'd6,
    OP_NNEG  = 4'd7,
    OP_LANE  = 4'd8,
    OP_EQIMM = 4'd9,
    OP_TEST  = 4'd10,
    OP_TESTI = 4'd11,
    OP_SET   = 4'd12,
    OP_CLR   = 4'd13,
    OP_MOVE  = 4'd14,
    OP_RSVD  = 4'd15
  } tf_op_e;

  // Ordering flags derived from one subtraction.
  typedef struct packed {
    logic eq;
    logic u_ge;
    logic u_gt;
    logic s_ge;
    logic s_gt;
  } rel_flags_t;

  function automatic logic [DATA_W-1:0] imm_sext(input logic [IMM_W-1:0] v);
    return {{(DATA_W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] imm_zext(input logic [IMM_W-1:0] v);
    return {{(DATA_W-IMM_W){1'b0}}, v};
  endfunction

  // a compared against b; borrow and overflow of a - b give every relation.
  function automatic rel_flags_t rel_eval(input logic [DATA_W-1:0] a,
                                          input logic [DATA_W-1:0] b);
    logic [DATA_W:0] diff;
    logic            ovf;
    logic            s_lt;
    rel_flags_t      f;
    diff   = {1'b0, a} - {1'b0, b};
    ovf    = (a[DATA_W-1] ^ b[DATA_W-1]) & (diff[DATA_W-1] ^ a[DATA_W-1]);
    s_lt   = diff[DATA_W-1] ^ ovf;
    f.eq   = (diff[DATA_W-1:0] == '0);
    f.u_ge = ~diff[DATA_W];
    f.u_gt = ~diff[DATA_W] & ~f.eq;
    f.s_ge = ~s_lt;
    f.s_gt = ~s_lt & ~f.eq;
    return f;
  endfunction

endpackage

// File: rtl/tflag_opsel.sv
module tflag_opsel
  import tflag_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int IW = IMM_W
) (
  input  tf_op_e        op,
  input  logic [W-1:0]  rm,
  input  logic [W-1:0]  rn,
  input  logic [W-1:0]  r0,
  input  logic [IW-1:0] imm,
  output logic [W-1:0]  rel_a,
  output logic [W-1:0]  rel_b,
  output logic [W-1:0]  tst_a,
  output logic [W-1:0]  tst_b
);
  // Relation operands: r0/sext(imm) for immediate equal, rn/0 for sign tests.
  always_comb begin
    rel_a = rn;
    rel_b = rm;
    unique case (op)
      OP_EQIMM: begin
        rel_a = r0;
        rel_b = imm_sext(imm);
      end
      OP_POS, OP_NNEG: rel_b = '0;
      default: ;
    endcase
  end

  // Test operands: immediate form always pairs r0 with zero-extended imm.
  always_comb begin
    if (op == OP_TESTI) begin
      tst_a = r0;
      tst_b = imm_zext(imm);
    end else begin
      tst_a = rn;
      tst_b = rm;
    end
  end
endmodule

// File: rtl/tflag_relcmp.sv
module tflag_relcmp
  import tflag_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output rel_flags_t   flags
);
  always_comb flags = rel_eval(a, b);
endmodule

// File: rtl/tflag_lanecmp.sv
module tflag_lanecmp
  import tflag_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int LW = LANE_W
) (
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  output logic [W/LW-1:0]   lane_hit,
  output logic              any_hit
);
  localparam int NLANE = W / LW;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane_hit[g] = (a[g*LW +: LW] == b[g*LW +: LW]);
  end

  assign any_hit = |lane_hit;
endmodule

// File: rtl/tflag_unit.sv
module tflag_unit
  import tflag_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int IW = IMM_W,
  parameter int LW = LANE_W
) (
  input  logic [3:0]    op,
  input  logic [W-1:0]  rm,
  input  logic [W-1:0]  rn,
  input  logic [W-1:0]  r0,
  input  logic [IW-1:0] imm,
  input  logic          t_in,
  output logic          t_next,
  output logic [W-1:0]  movt_val
);
  localparam int NLANE = W / LW;

  tf_op_e           op_e;
  logic [W-1:0]     rel_a, rel_b, tst_a, tst_b;
  rel_flags_t       rel;
  logic [NLANE-1:0] lane_hit;
  logic             lane_any;
  logic             tst_zero;

  assign op_e = tf_op_e'(op);

  tflag_opsel #(.W(W), .IW(IW)) u_sel (
    .op(op_e), .rm(rm), .rn(rn), .r0(r0), .imm(imm),
    .rel_a(rel_a), .rel_b(rel_b), .tst_a(tst_a), .tst_b(tst_b)
  );

  tflag_relcmp #(.W(W)) u_rel (.a(rel_a), .b(rel_b), .flags(rel));

  tflag_lanecmp #(.W(W), .LW(LW)) u_lane (
    .a(rn), .b(rm), .lane_hit(lane_hit), .any_hit(lane_any)
  );

  assign tst_zero = ((tst_a & tst_b) == '0);

  always_comb begin
    t_next = t_in;
    unique case (op_e)
      OP_EQ, OP_EQIMM:  t_next = rel.eq;
      OP_SGE, OP_NNEG:  t_next = rel.s_ge;
      OP_SGT, OP_POS:   t_next = rel.s_gt;
      OP_UGT:           t_next = rel.u_gt;
      OP_UGE:           t_next = rel.u_ge;
      OP_LANE:          t_next = lane_any;
      OP_TEST, OP_TESTI: t_next = tst_zero;
      OP_SET:           t_next = 1'b1;
      OP_CLR:           t_next = 1'b0;
      default:          t_next = t_in;
    endcase
  end

  assign movt_val = (op_e == OP_MOVE) ? {{(W-1){1'b0}}, t_in} : '0;
endmodule

// File: rtl/tflag_unit_chk.sv
module tflag_unit_chk #(
  parameter int W  = 32,
  parameter int IW = 8,
  parameter int NL = 4
) (
  input logic [3:0]    op,
  input logic [W-1:0]  rm,
  input logic [W-1:0]  rn,
  input logic [W-1:0]  r0,
  input logic [IW-1:0] imm,
  input logic          t_in,
  input logic          t_next,
  input logic [W-1:0]  movt_val,
  input logic [NL-1:0] lane_hit
);
  always_comb begin
    if (op == 4'd1)
      a_r1_eq: assert (t_next == (rn == rm));
    if (op == 4'd3)
      a_r2_sgt: assert (t_next == ($signed(rn) > $signed(rm)));
    if (op == 4'd4)
      a_r3_ugt: assert (t_next == (rn > rm));
    if (op == 4'd7)
      a_r4_nneg: assert (t_next == ~rn[W-1]);
    if (op == 4'd8)
      a_r5_lane: assert (t_next == (lane_hit != '0));
    if (op == 4'd9)
      a_r6_eqimm: assert (t_next == ($signed(r0) == $signed(imm)));
    if (op == 4'd12)
      a_r8_set: assert (t_next);
    if (op == 4'd13)
      a_r8_clr: assert (!t_next);
    a_r9_movt_width: assert (movt_val[W-1:1] == '0);
    if (op != 4'd14)
      a_r9_movt_idle: assert (movt_val == '0);
    if (op == 4'd0 || op == 4'd14 || op == 4'd15)
      a_r10_hold: assert (t_next == t_in);
  end
endmodule

bind tflag_unit tflag_unit_chk #(.W(W), .IW(IW), .NL(NLANE)) u_chk (
  .op(op), .rm(rm), .rn(rn), .r0(r0), .imm(imm), .t_in(t_in),
  .t_next(t_next), .movt_val(movt_val), .lane_hit(lane_hit)
);

// File: tb/sim_tflag_unit.sv
module sim_tflag_unit;
  localparam int VW = 4 + 32 + 32 + 32 + 8 + 1 + 1;
  localparam int NV = 31;

  // {op, rm, rn, r0, imm, t_in, expected t_next}
  localparam logic [VW-1:0] TBL [NV] = '{
    {4'd1,  32'h12345678, 32'h12345678, 32'h0, 8'h00, 1'b0, 1'b1}, // R1
    {4'd1,  32'h12345678, 32'h12345679, 32'h0, 8'h00, 1'b1, 1'b0}, // R1
    {4'd2,  32'hFFFFFFFF, 32'h00000000, 32'h0, 8'h00, 1'b0, 1'b1}, // R2
    {4'd2,  32'h00000005, 32'h00000005, 32'h0, 8'h00, 1'b0, 1'b1}, // R2
    {4'd3,  32'h00000005, 32'h00000005, 32'h0, 8'h00, 1'b1, 1'b0}, // R2
    {4'd3,  32'h80000000, 32'h7FFFFFFF, 32'h0, 8'h00, 1'b0, 1'b1}, // R2
    {4'd4,  32'h00000000, 32'hFFFFFFFF, 32'h0, 8'h00, 1'b0, 1'b1}, // R3
    {4'd4,  32'hFFFFFFFF, 32'h00000000, 32'h0, 8'h00, 1'b1, 1'b0}, // R3
    {4'd5,  32'h0000000A, 32'h0000000A, 32'h0, 8'h00, 1'b0, 1'b1}, // R3
    {4'd5,  32'h80000000, 32'h7FFFFFFF, 32'h0, 8'h00, 1'b1, 1'b0}, // R3
    {4'd6,  32'h00000000, 32'h00000000, 32'h0, 8'h00, 1'b1, 1'b0}, // R4
    {4'd6,  32'h00000000, 32'h00000001, 32'h0, 8'h00, 1'b0, 1'b1}, // R4
    {4'd6,  32'h00000000, 32'h80000000, 32'h0, 8'h00, 1'b1, 1'b0}, // R4
    {4'd7,  32'h00000005, 32'h00000000, 32'h0, 8'h00, 1'b0, 1'b1}, // R4
    {4'd7,  32'h00000000, 32'hFFFFFFFF, 32'h0, 8'h00, 1'b1, 1'b0}, // R4
    {4'd8,  32'h11223344, 32'h55226677, 32'h0, 8'h00, 1'b0, 1'b1}, // R5
    {4'd8,  32'h11223344, 32'h22114433, 32'h0, 8'h00, 1'b1, 1'b0}, // R5
    {4'd8,  32'hAABBCCDD, 32'h000000DD, 32'h0, 8'h00, 1'b0, 1'b1}, // R5
    {4'd9,  32'h0, 32'h0, 32'hFFFFFF80, 8'h80, 1'b0, 1'b1},         // R6
    {4'd9,  32'h0, 32'h0, 32'h00000080, 8'h80, 1'b1, 1'b0},         // R6
    {4'd9,  32'h0, 32'h0, 32'h0000007F, 8'h7F, 1'b0, 1'b1},         // R6
    {4'd10, 32'h000000F0, 32'h0000000F, 32'h0, 8'h00, 1'b0, 1'b1}, // R7
    {4'd10, 32'h000000F0, 32'h00000010, 32'h0, 8'h00, 1'b1, 1'b0}, // R7
    {4'd11, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFF00, 8'hFF, 1'b0, 1'b1}, // R7
    {4'd11, 32'h0, 32'h0, 32'h00000001, 8'hFF, 1'b1, 1'b0},         // R7
    {4'd12, 32'h1, 32'h2, 32'h3, 8'h04, 1'b0, 1'b1},                // R8
    {4'd13, 32'h5, 32'h5, 32'h0, 8'h00, 1'b1, 1'b0},                // R8
    {4'd14, 32'h0, 32'h0, 32'h0, 8'h00, 1'b1, 1'b1},                // R9
    {4'd14, 32'h0, 32'h0, 32'h0, 8'h00, 1'b0, 1'b0},                // R9
    {4'd0,  32'h7, 32'h7, 32'h0, 8'h00, 1'b1, 1'b1},                // R10
    {4'd15, 32'h7, 32'h7, 32'h0, 8'h00, 1'b0, 1'b0}                 // R10
  };

  logic        clk = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] rm = '0, rn = '0, r0 = '0;
  logic [7:0]  imm = '0;
  logic        t_in = 1'b0;
  logic        t_next;
  logic [31:0] movt_val;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  tflag_unit u0 (
    .op(op), .rm(rm), .rn(rn), .r0(r0), .imm(imm), .t_in(t_in),
    .t_next(t_next), .movt_val(movt_val)
  );

  task automatic drive(input logic [3:0] o, input logic [31:0] a_rm,
                       input logic [31:0] a_rn, input logic [31:0] a_r0,
                       input logic [7:0] a_imm, input logic a_t);
    @(posedge clk);
    #1;
    op = o; rm = a_rm; rn = a_rn; r0 = a_r0; imm = a_imm; t_in = a_t;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd1: return "R1";
      4'd2, 4'd3: return "R2";
      4'd4, 4'd5: return "R3";
      4'd6, 4'd7: return "R4";
      4'd8: return "R5";
      4'd9: return "R6";
      4'd10, 4'd11: return "R7";
      4'd12, 4'd13: return "R8";
      4'd14: return "R9";
      default: return "R10";
    endcase
  endfunction

  initial begin
    // Idle state: no operation, T passes through, move output quiet (R10, R9)
    drive(4'd0, '0, '0, '0, '0, 1'b0);
    check("R10 idle t_next", {31'b0, t_next}, 32'd0);
    check("R9 idle movt_val", movt_val, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = TBL[i];
      drive(v[109:106], v[105:74], v[73:42], v[41:10], v[9:2], v[1]);
      check($sformatf("%s vec%0d t_next", req_of(v[109:106]), i),
            {31'b0, t_next}, {31'b0, v[0]});
      // R9: move output carries T only for op 14
      check($sformatf("R9 vec%0d movt_val", i), movt_val,
            (v[109:106] == 4'd14) ? {31'b0, v[1]} : 32'd0);
    end

    // R5: all lanes equal
    drive(4'd8, 32'hDEADBEEF, 32'hDEADBEEF, '0, '0, 1'b0);
    check("R5 all lanes", {31'b0, t_next}, 32'd1);
    // R5: only the top lane matches
    drive(4'd8, 32'hAB000000, 32'hAB111111, '0, '0, 1'b0);
    check("R5 top lane", {31'b0, t_next}, 32'd1);
    // R1: r0 and imm play no part in the register equal
    drive(4'd1, 32'h1, 32'h2, 32'h1, 8'h02, 1'b1);
    check("R1 ignores r0", {31'b0, t_next}, 32'd0);
    // R6: rn and rm play no part in the immediate equal
    drive(4'd9, 32'h5, 32'h5, 32'h00000003, 8'h05, 1'b1);
    check("R6 ignores rn rm", {31'b0, t_next}, 32'd0);
    // R7: immediate test does not use rn
    drive(4'd11, 32'h0, 32'h0, 32'h00000080, 8'h80, 1'b1);
    check("R7 imm test nonzero", {31'b0, t_next}, 32'd0);
    // R2: signed GE at the minimum against itself
    drive(4'd2, 32'h80000000, 32'h80000000, '0, '0, 1'b0);
    check("R2 min ge min", {31'b0, t_next}, 32'd1);
    // R3: unsigned higher-or-same, zero against max
    drive(4'd5, 32'hFFFFFFFF, 32'h00000000, '0, '0, 1'b1);
    check("R3 zero hs max", {31'b0, t_next}, 32'd0);
    // R8: clear with T already 0
    drive(4'd13, '0, '0, '0, '0, 1'b0);
    check("R8 clear stays 0", {31'b0, t_next}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule